// File: doc/BRIEF.md
# Column-Pair Ping-Pong Tile Buffer

This block moves one feature-map tile, channel by channel, from external memory through a per-element processing stage (such as a normalization pipeline) and back to memory. It does not hold a whole tile. It uses two small banks, and each bank holds one pair of adjacent columns. A pair of columns has 2×TILE_H words. Because the two columns are always present together, every 2×2 pooling window is complete inside a single bank. Total storage is 4×TILE_H words, where a whole-tile buffer would need TILE_W×TILE_H.

The banks work as a ping-pong pair. At the start, bank 0 loads the first column pair while the processing stage waits. Bank 1 then loads the next pair while bank 0 streams to the processing stage. Results come back into the bank they came from and are then written out. When the last write of a bank is accepted, that bank is free, and this releases the read of the next column pair into it. The block steps through every column pair of a channel and then every channel, all from a single start pulse.

Memory layout is column-major within a channel, with channels stored back to back. The word at row r, column c, channel k therefore sits at address k×TILE_W×TILE_H + c×TILE_H + r. Results are written back in place, at the address of their source word.

Top module: `ppb_tile_pingpong`

## Requirements
- R1: After reset and while idle, `busy_o`, `done_o`, `rd_req_valid_o`, `pr_out_valid_o` and `wr_valid_o` are all 0.
- R2: Each tile word is requested exactly once per run. Requests go one column pair after another, column-major inside a pair, so the n-th request of a run carries address n.
- R3: Inside a bank, words go to the processing stage one row pair at a time, in the order (r,c), (r,c+1), (r+1,c), (r+1,c+1), where c is the pair's left column and r is even.
- R4: The result for the word at address a is written to address a, exactly once. The writes of a run leave in ascending address order.
- R5: No word of a column pair goes to the processing stage before all 2×TILE_H read responses of that pair have been accepted.
- R6: A read request for column pair p (p ≥ 2) is issued only after every write of pair p−2 has been accepted. At most two pairs are resident at any time.
- R7: After the last column pair of channel k, the next read request starts at the base of channel k+1, which is (k+1)×TILE_W×TILE_H.
- R8: `done_o` is high for exactly one cycle. It starts one clock after the edge that accepts the final write of the run, and `busy_o` falls at the same edge.
- R9: While a valid output (read request, processing stream or write) is not accepted, it stays valid and its payload stays unchanged.
- R10: A `start_i` pulse while `busy_o` is 1 has no effect: the run continues and completes exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a full tile run (ignored while busy) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the run ends |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Memory accepts the read request |
| rd_req_addr_o | output | ADDR_W | Word address to read |
| rd_rsp_valid_i | input | 1 | Read data returned, in request order |
| rd_rsp_data_i | input | DATA_W | Returned word |
| pr_out_valid_o | output | 1 | Word offered to the processing stage |
| pr_out_ready_i | input | 1 | Processing stage accepts the word |
| pr_out_data_o | output | DATA_W | Word to process |
| pr_res_valid_i | input | 1 | Processed result, in stream order |
| pr_res_data_i | input | DATA_W | Processed word |
| wr_valid_o | output | 1 | Write valid |
| wr_ready_i | input | 1 | Memory accepts the write |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |

## Verification
The hardest state to reach is the one where both banks are in use at once: one bank has finished processing and waits for a write that memory keeps refusing, while the other bank is already full or streaming. Only in that state do the gate on the next read (R6) and the in-order bank rotation matter. To reach it, the stimulus pairs short read latency with a write sink that accepts only about one cycle in four. Other runs instead stall the processing stage and return results late, which exercises the hold behaviour of the streaming port.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    typedef enum logic [2:0] {
        BUF_EMPTY,
        BUF_FILLING,
        BUF_FULL,
        BUF_PROCESSING,
        BUF_WRITING
    } buf_state_e;

    // Bank slot (column-major, col*rows + row) of the k-th word in
    // 2x2-window order.
    function automatic int unsigned win_slot(input int unsigned k, input int unsigned rows);
        int unsigned row_pair;
        int unsigned sub;
        row_pair = k / 4;
        sub      = k % 4;
        return (sub % 2) * rows + 2 * row_pair + sub / 2;
    endfunction

endpackage

// File: rtl/ppb_col_store.sv
module ppb_col_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) mem_q[widx_i] <= wdata_i;
    end

    assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/ppb_pair_seq.sv
module ppb_pair_seq #(
    parameter int ADDR_W = 16,
    parameter int STEP   = 8,
    parameter int TOTAL  = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              restart_i,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] base_o,
    output logic              more_o
);
    localparam int PC_W = $clog2(TOTAL + 1);

    logic [ADDR_W-1:0] base_q;
    logic [PC_W-1:0]   left_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            base_q <= '0;
            left_q <= '0;
        end else if (restart_i) begin
            base_q <= '0;
            left_q <= PC_W'(TOTAL);
        end else if (advance_i && left_q != '0) begin
            base_q <= base_q + ADDR_W'(STEP);
            left_q <= left_q - 1'b1;
        end
    end

    assign base_o = base_q;
    assign more_o = (left_q != '0);
endmodule

// File: rtl/ppb_tile_pingpong.sv
module ppb_tile_pingpong
    import ppb_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 16,
    parameter int TILE_H   = 4,
    parameter int TILE_W   = 6,
    parameter int CHANNELS = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_req_valid_o,
    input  logic              rd_req_ready_i,
    output logic [ADDR_W-1:0] rd_req_addr_o,
    input  logic              rd_rsp_valid_i,
    input  logic [DATA_W-1:0] rd_rsp_data_i,
    output logic              pr_out_valid_o,
    input  logic              pr_out_ready_i,
    output logic [DATA_W-1:0] pr_out_data_o,
    input  logic              pr_res_valid_i,
    input  logic [DATA_W-1:0] pr_res_data_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int BUF_N       = 2 * TILE_H;
    localparam int IDX_W       = $clog2(BUF_N);
    localparam int CNT_W       = $clog2(BUF_N + 1);
    localparam int TOTAL_PAIRS = CHANNELS * (TILE_W / 2);

    if ((TILE_W % 2) != 0 || (TILE_H % 2) != 0) begin : g_bad_geometry
        $error("tile width and height must both be even");
    end

    logic              active_q, done_q;
    buf_state_e        buf_st_q [2];
    logic [ADDR_W-1:0] base_q   [2];
    logic              fsel_q, psel_q, wsel_q;
    logic [CNT_W-1:0]  rq_cnt_q, rs_cnt_q, tx_cnt_q, rx_cnt_q, wr_cnt_q;
    logic [DATA_W-1:0] bank_rdata [2];

    logic [ADDR_W-1:0] seq_base;
    logic              seq_more;

    logic start_go, fill_begin, rd_fire, rsp_take, fill_last;
    logic proc_begin, po_fire, res_take, proc_last;
    logic wr_fire, wr_last, run_fin;
    logic [IDX_W-1:0] tx_slot, rx_slot;

    assign start_go   = start_i && !active_q;
    assign fill_begin = active_q && seq_more && buf_st_q[fsel_q] == BUF_EMPTY;
    assign rd_fire    = rd_req_valid_o && rd_req_ready_i;
    assign rsp_take   = rd_rsp_valid_i && buf_st_q[fsel_q] == BUF_FILLING;
    assign fill_last  = rsp_take && rs_cnt_q == CNT_W'(BUF_N - 1);
    assign proc_begin = buf_st_q[psel_q] == BUF_FULL;
    assign po_fire    = pr_out_valid_o && pr_out_ready_i;
    assign res_take   = pr_res_valid_i && buf_st_q[psel_q] == BUF_PROCESSING;
    assign proc_last  = res_take && rx_cnt_q == CNT_W'(BUF_N - 1);
    assign wr_fire    = wr_valid_o && wr_ready_i;
    assign wr_last    = wr_fire && wr_cnt_q == CNT_W'(BUF_N - 1);
    assign run_fin    = active_q && !seq_more &&
                        buf_st_q[0] == BUF_EMPTY && buf_st_q[1] == BUF_EMPTY;

    assign tx_slot = IDX_W'(win_slot(32'(tx_cnt_q), TILE_H));
    assign rx_slot = IDX_W'(win_slot(32'(rx_cnt_q), TILE_H));

    ppb_pair_seq #(
        .ADDR_W (ADDR_W),
        .STEP   (BUF_N),
        .TOTAL  (TOTAL_PAIRS)
    ) seq_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (start_go),
        .advance_i (fill_begin),
        .base_o    (seq_base),
        .more_o    (seq_more)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic             fill_we, res_we;
        logic [IDX_W-1:0] ridx;
        assign fill_we = rsp_take && fsel_q == 1'(b);
        assign res_we  = res_take && psel_q == 1'(b);
        assign ridx    = (buf_st_q[b] == BUF_PROCESSING) ? tx_slot : IDX_W'(wr_cnt_q);

        ppb_col_store #(
            .DATA_W (DATA_W),
            .DEPTH  (BUF_N),
            .IDX_W  (IDX_W)
        ) store_i (
            .clk_i   (clk_i),
            .we_i    (fill_we || res_we),
            .widx_i  (res_we ? rx_slot : IDX_W'(rs_cnt_q)),
            .wdata_i (res_we ? pr_res_data_i : rd_rsp_data_i),
            .ridx_i  (ridx),
            .rdata_o (bank_rdata[b])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            active_q    <= 1'b0;
            done_q      <= 1'b0;
            buf_st_q[0] <= BUF_EMPTY;
            buf_st_q[1] <= BUF_EMPTY;
            base_q[0]   <= '0;
            base_q[1]   <= '0;
            fsel_q      <= 1'b0;
            psel_q      <= 1'b0;
            wsel_q      <= 1'b0;
            rq_cnt_q    <= '0;
            rs_cnt_q    <= '0;
            tx_cnt_q    <= '0;
            rx_cnt_q    <= '0;
            wr_cnt_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_go) begin
                active_q <= 1'b1;
                fsel_q   <= 1'b0;
                psel_q   <= 1'b0;
                wsel_q   <= 1'b0;
            end
            if (run_fin) begin
                active_q <= 1'b0;
                done_q   <= 1'b1;
            end
            // fill engine
            if (fill_begin) begin
                buf_st_q[fsel_q] <= BUF_FILLING;
                base_q[fsel_q]   <= seq_base;
                rq_cnt_q         <= '0;
                rs_cnt_q         <= '0;
            end else begin
                if (rd_fire) rq_cnt_q <= rq_cnt_q + 1'b1;
                if (rsp_take) begin
                    rs_cnt_q <= rs_cnt_q + 1'b1;
                    if (fill_last) begin
                        buf_st_q[fsel_q] <= BUF_FULL;
                        fsel_q           <= ~fsel_q;
                    end
                end
            end
            // processing engine
            if (proc_begin) begin
                buf_st_q[psel_q] <= BUF_PROCESSING;
                tx_cnt_q         <= '0;
                rx_cnt_q         <= '0;
            end else begin
                if (po_fire) tx_cnt_q <= tx_cnt_q + 1'b1;
                if (res_take) begin
                    rx_cnt_q <= rx_cnt_q + 1'b1;
                    if (proc_last) begin
                        buf_st_q[psel_q] <= BUF_WRITING;
                        psel_q           <= ~psel_q;
                    end
                end
            end
            // write engine
            if (wr_fire) begin
                if (wr_last) begin
                    buf_st_q[wsel_q] <= BUF_EMPTY;
                    wsel_q           <= ~wsel_q;
                    wr_cnt_q         <= '0;
                end else begin
                    wr_cnt_q <= wr_cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy_o         = active_q;
    assign done_o         = done_q;
    assign rd_req_valid_o = buf_st_q[fsel_q] == BUF_FILLING && rq_cnt_q < CNT_W'(BUF_N);
    assign rd_req_addr_o  = base_q[fsel_q] + ADDR_W'(rq_cnt_q);
    assign pr_out_valid_o = buf_st_q[psel_q] == BUF_PROCESSING && tx_cnt_q < CNT_W'(BUF_N);
    assign pr_out_data_o  = bank_rdata[psel_q];
    assign wr_valid_o     = buf_st_q[wsel_q] == BUF_WRITING;
    assign wr_addr_o      = base_q[wsel_q] + ADDR_W'(wr_cnt_q);
    assign wr_data_o      = bank_rdata[wsel_q];
endmodule

// File: rtl/ppb_tile_pingpong_chk.sv
module ppb_tile_pingpong_chk
    import ppb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              rd_req_valid_o,
    input logic              rd_req_ready_i,
    input logic [ADDR_W-1:0] rd_req_addr_o,
    input logic              pr_out_valid_o,
    input logic              pr_out_ready_i,
    input logic [DATA_W-1:0] pr_out_data_o,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [DATA_W-1:0] wr_data_o,
    input buf_state_e        st_a,
    input buf_state_e        st_b
);
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> !rd_req_valid_o && !pr_out_valid_o && !wr_valid_o); // R1

    AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o)); // R9

    AST_PO_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        pr_out_valid_o && !pr_out_ready_i |=> pr_out_valid_o && $stable(pr_out_data_o)); // R9

    AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R9

    AST_ONE_FILLER: assert property (@(posedge clk_i) disable iff (rst_i)
        !(st_a == BUF_FILLING && st_b == BUF_FILLING)); // R6

    AST_ONE_PROCESSOR: assert property (@(posedge clk_i) disable iff (rst_i)
        !(st_a == BUF_PROCESSING && st_b == BUF_PROCESSING)); // R6

    AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !busy_o && $fell(busy_o)); // R8
endmodule

bind ppb_tile_pingpong ppb_tile_pingpong_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_req_addr_o  (rd_req_addr_o),
    .pr_out_valid_o (pr_out_valid_o),
    .pr_out_ready_i (pr_out_ready_i),
    .pr_out_data_o  (pr_out_data_o),
    .wr_valid_o     (wr_valid_o),
    .wr_ready_i     (wr_ready_i),
    .wr_addr_o      (wr_addr_o),
    .wr_data_o      (wr_data_o),
    .st_a           (buf_st_q[0]),
    .st_b           (buf_st_q[1])
);

// File: tb/ppb_tile_pingpong_tb.sv
module ppb_tile_pingpong_tb_top;
    localparam int DW    = 16;
    localparam int AW    = 16;
    localparam int H     = 4;
    localparam int W     = 6;
    localparam int CH    = 2;
    localparam int PAIRN = 2 * H;
    localparam int TOT   = CH * W * H;

    // run vector: {read latency max, stream stall, result latency max, write stall}
    localparam logic [15:0] RUN_VEC [4] = '{16'h1010, 16'h4232, 16'h2103, 16'h3321};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic busy_o, done_o;
    logic rd_req_valid_o, rd_req_ready_i = 1'b0;
    logic [AW-1:0] rd_req_addr_o;
    logic rd_rsp_valid_i = 1'b0;
    logic [DW-1:0] rd_rsp_data_i = '0;
    logic pr_out_valid_o, pr_out_ready_i = 1'b0;
    logic [DW-1:0] pr_out_data_o;
    logic pr_res_valid_i = 1'b0;
    logic [DW-1:0] pr_res_data_i = '0;
    logic wr_valid_o, wr_ready_i = 1'b0;
    logic [AW-1:0] wr_addr_o;
    logic [DW-1:0] wr_data_o;

    always #5 clk = ~clk;

    ppb_tile_pingpong #(.DATA_W(DW), .ADDR_W(AW), .TILE_H(H), .TILE_W(W), .CHANNELS(CH)) dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i), .rd_req_addr_o(rd_req_addr_o),
        .rd_rsp_valid_i(rd_rsp_valid_i), .rd_rsp_data_i(rd_rsp_data_i),
        .pr_out_valid_o(pr_out_valid_o), .pr_out_ready_i(pr_out_ready_i), .pr_out_data_o(pr_out_data_o),
        .pr_res_valid_i(pr_res_valid_i), .pr_res_data_i(pr_res_data_i),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ival(input int a);
        return DW'(a * 37 + 5);
    endfunction

    function automatic logic [DW-1:0] fres(input logic [DW-1:0] d);
        return DW'(d * 3 + 1);
    endfunction

    // expected address of the n-th streamed word (window order inside each pair)
    function automatic int stream_addr(input int n);
        int k, rp, sub;
        k   = n % PAIRN;
        rp  = k / 4;
        sub = k % 4;
        return (n / PAIRN) * PAIRN + (sub % 2) * H + 2 * rp + sub / 2;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        start_i = 1'b0;
        rd_req_ready_i = 1'b0;
        rd_rsp_valid_i = 1'b0;
        pr_out_ready_i = 1'b0;
        pr_res_valid_i = 1'b0;
        wr_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_tile(input logic [15:0] v, input bit restart_mid);
        int rsp_due[$];
        logic [DW-1:0] rsp_dat[$];
        int res_due[$];
        logic [DW-1:0] res_dat[$];
        int rd_hits[TOT];
        int wr_hits[TOT];
        int cyc = 0, n_req = 0, n_rsp = 0, n_po = 0, n_wr = 0, n_done = 0;
        int last_wr_cyc = -10;
        bit finished = 0;
        bit pend_rd = 0, pend_wr = 0;
        int pend_rd_a = 0, pend_wr_a = 0;
        int rd_lat = int'(v[15:12]), po_st = int'(v[11:8]);
        int rs_lat = int'(v[7:4]), wr_st = int'(v[3:0]);
        for (int i = 0; i < TOT; i++) begin
            rd_hits[i] = 0;
            wr_hits[i] = 0;
        end
        do_reset();
        while (!finished && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            // end-of-run timing (R8)
            if (cyc == last_wr_cyc + 1) begin
                chk(done_o == 1'b0, "R8 done early", int'(done_o), 0);
                chk(busy_o == 1'b1, "R8 busy dropped early", int'(busy_o), 1);
            end
            if (cyc == last_wr_cyc + 2) begin
                chk(done_o == 1'b1, "R8 done pulse", int'(done_o), 1);
                chk(busy_o == 1'b0, "R8 busy after done", int'(busy_o), 0);
                finished = 1;
            end
            if (done_o) n_done++;
            if (restart_mid && cyc == 41)
                chk(busy_o == 1'b1, "R10 run continues after extra start", int'(busy_o), 1);
            // drive inputs
            start_i = (cyc == 1) || (restart_mid && cyc == 40);
            rd_req_ready_i = ($urandom_range(0, 3) >= 1);
            if (rsp_due.size() > 0 && rsp_due[0] <= cyc) begin
                rd_rsp_valid_i = 1'b1;
                rd_rsp_data_i = rsp_dat.pop_front();
                void'(rsp_due.pop_front());
            end else begin
                rd_rsp_valid_i = 1'b0;
            end
            pr_out_ready_i = (int'($urandom_range(0, 3)) >= po_st);
            if (res_due.size() > 0 && res_due[0] <= cyc) begin
                pr_res_valid_i = 1'b1;
                pr_res_data_i = res_dat.pop_front();
                void'(res_due.pop_front());
            end else begin
                pr_res_valid_i = 1'b0;
            end
            wr_ready_i = (int'($urandom_range(0, 3)) >= wr_st);
            #1;
            // hold checks (R9)
            if (pend_rd)
                chk(rd_req_valid_o && int'(rd_req_addr_o) == pend_rd_a, "R9 read request held",
                    int'(rd_req_addr_o), pend_rd_a);
            if (pend_wr)
                chk(wr_valid_o && int'(wr_addr_o) == pend_wr_a, "R9 write held",
                    int'(wr_addr_o), pend_wr_a);
            pend_rd = rd_req_valid_o && !rd_req_ready_i;
            pend_rd_a = int'(rd_req_addr_o);
            pend_wr = wr_valid_o && !wr_ready_i;
            pend_wr_a = int'(wr_addr_o);
            // stream handshake (R3, R5)
            if (pr_out_valid_o && pr_out_ready_i) begin
                chk(n_rsp >= (n_po / PAIRN + 1) * PAIRN, "R5 stream before pair loaded",
                    n_rsp, (n_po / PAIRN + 1) * PAIRN);
                chk(pr_out_data_o == ival(stream_addr(n_po)), "R3 window order",
                    int'(pr_out_data_o), int'(ival(stream_addr(n_po))));
                res_dat.push_back(fres(pr_out_data_o));
                res_due.push_back(cyc + int'($urandom_range(1, rs_lat)));
                n_po++;
            end
            if (rd_rsp_valid_i) n_rsp++;
            // read request (R2, R6, R7)
            if (rd_req_valid_o && rd_req_ready_i) begin
                int a = int'(rd_req_addr_o);
                chk(a == n_req, "R2 read address sequence", a, n_req);
                if (n_req == W * H)
                    chk(a == W * H, "R7 next channel base", a, W * H);
                if (n_req / PAIRN >= 2)
                    chk(n_wr >= (n_req / PAIRN - 1) * PAIRN, "R6 read before bank written back",
                        n_wr, (n_req / PAIRN - 1) * PAIRN);
                if (a >= 0 && a < TOT) begin
                    rd_hits[a]++;
                    rsp_dat.push_back(ival(a));
                end else begin
                    rsp_dat.push_back('0);
                end
                rsp_due.push_back(cyc + int'($urandom_range(1, rd_lat)));
                n_req++;
            end
            // write (R4)
            if (wr_valid_o && wr_ready_i) begin
                int a = int'(wr_addr_o);
                chk(a == n_wr, "R4 write address order", a, n_wr);
                chk(wr_data_o == fres(ival(a)), "R4 write data", int'(wr_data_o), int'(fres(ival(a))));
                if (a >= 0 && a < TOT) wr_hits[a]++;
                n_wr++;
                if (n_wr == TOT) last_wr_cyc = cyc;
            end
        end
        if (!finished) chk(1'b0, "R8 watchdog expired", cyc, 4000);
        begin
            int bad_rd = 0, bad_wr = 0;
            for (int i = 0; i < TOT; i++) begin
                if (rd_hits[i] != 1) bad_rd++;
                if (wr_hits[i] != 1) bad_wr++;
            end
            chk(bad_rd == 0, "R2 each word read once", bad_rd, 0);
            chk(bad_wr == 0, "R4 each word written once", bad_wr, 0);
            chk(n_done == 1, restart_mid ? "R10 single completion" : "R8 single done", n_done, 1);
        end
        // after the run all outputs quiet (R1)
        @(negedge clk);
        start_i = 1'b0;
        chk(!rd_req_valid_o && !pr_out_valid_o && !wr_valid_o && !busy_o,
            "R1 quiet after run", int'(busy_o), 0);
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
        chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        chk(!rd_req_valid_o && !pr_out_valid_o && !wr_valid_o, "R1 valids after reset",
            int'({rd_req_valid_o, pr_out_valid_o, wr_valid_o}), 0);
        repeat (5) @(negedge clk);
        chk(!rd_req_valid_o && !busy_o, "R1 idle without start", int'(busy_o), 0);
        for (int r = 0; r < 4; r++) begin
            run_tile(RUN_VEC[r], r == 1);
        end
        // directed: extra start while busy under heavy write stall (R10)
        run_tile(16'h1103, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL R8 global watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule